// File: doc/BRIEF.md
# Time-Division Codec Link Frame Engine

This block runs the serial side of a time-division audio link to a codec. The codec supplies the bit clock. The engine counts a fixed frame of 16 slots of 16 bits, which is 256 bit periods. Once per frame it raises an active-high frame sync that leads slot 0 by one bit. In every slot it shifts out one transmit word, most significant bit first. A controller loads these words into a parallel slot array, and the engine takes a copy of that array when each frame starts.

The incoming serial stream is deserialized at the same time. Only the first five slots are kept. When the last bit of slot 4 has been taken in, all five words move into the receive bank together, and a one-cycle pulse marks that the bank is new. A second one-cycle strobe marks each frame boundary.

The engine runs on a fast system clock. It synchronizes the bit clock and acts on each of its falling edges, both to drive data and to sample data. The bit clock therefore needs a high phase and a low phase of at least three system-clock cycles each.

Top module: `tdm_link_engine`

## Requirements
- R1: While reset is active and after it is released, until the first bit-clock falling edge: `sdOut`, `frameSync`, `frameDone` and `rxValid` are 0 and `rxSlots` is all zeros. The first falling edge after reset starts the sync bit of the first frame.
- R2: `frameSync` is high for exactly one bit period in every 256. That period is the last bit of slot 15, directly before the MSB of slot 0. `frameSync` changes only after a bit-clock falling edge.
- R3: In bit position p of a frame (p = 16*s + k, k = 0..15), `sdOut` carries bit 15-k of transmit slot s. Slot s is read from `txSlots[16*s+15:16*s]`. `sdOut` changes only after a bit-clock falling edge.
- R4: The engine copies `txSlots` at the falling edge that raises `frameSync`. A change to `txSlots` during a frame leaves that frame's serial output unchanged and appears in the next frame.
- R5: The value of `sdIn` is sampled at the falling edge that ends each bit period, MSB first. The words of slots 0 to 4 appear in `rxSlots[16*s+15:16*s]`, all in the same cycle, one system clock after the falling edge that ends slot 4. `rxValid` is high for exactly that one cycle.
- R6: `frameDone` is high for exactly one system-clock cycle, after the falling edge that ends the last bit of slot 15. It rises in the same cycle that `frameSync` falls.
- R7: Data on `sdIn` in slots 5 to 15 has no effect on `rxSlots`. `rxSlots` changes only in a cycle where `rxValid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bitClk | input | 1 | Bit clock from the codec (asynchronous) |
| sdIn | input | 1 | Serial data from the codec |
| txSlots | input | 256 | Transmit words; slot s at bits 16s+15:16s |
| sdOut | output | 1 | Serial data to the codec |
| frameSync | output | 1 | Active-high frame sync, one bit early |
| frameDone | output | 1 | One-cycle strobe at each frame boundary |
| rxSlots | output | 80 | Receive bank; slot s at bits 16s+15:16s |
| rxValid | output | 1 | One-cycle strobe when the receive bank updates |

## Verification
The hardest cases to reach from the ports are the timing of a `txSlots` update against the frame copy, and the claim that late receive slots are ignored. Both play out over a whole 256-bit frame.

The bench acts as the codec. It drives every bit-clock period itself and keeps its own count of the bit position. At position 100 of each frame it rewrites the transmit array, so each frame must still carry the old words while the next frame carries the new ones.

It drives distinct, nonzero data into slots 5 to 15 on `sdIn`. At the end of each frame it compares the receive bank with what was captured at its single update pulse. The frames sweep six data patterns: all zeros, all ones, walking one, alternating bits, and two arithmetic patterns.

// File: rtl/tdm_link_pkg.sv
package tdm_link_pkg;

  // Width of the slot index carried in the strobe bundle (up to 256 slots).
  localparam int SLOT_IDX_W = 8;

  // Strobes from the frame control to the serial datapath, all valid in one clk cycle.
  typedef struct packed {
    logic                  tick;     // bit-clock falling edge seen this cycle
    logic                  loadTx;   // take a copy of the transmit array (frame start)
    logic                  wordEnd;  // last bit of a captured receive slot is on sdIn
    logic                  publish;  // the word ending now is the last captured slot
    logic [SLOT_IDX_W-1:0] slotIdx;  // slot whose bit is on the wire before this edge
  } link_strobe_t;

endpackage

// File: rtl/tdm_link_ctrl.sv
module tdm_link_ctrl
  import tdm_link_pkg::*;
#(
  parameter int SLOT_W    = 16,
  parameter int NUM_SLOTS = 16,
  parameter int RX_SLOTS  = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bitClk,
  output logic         frameSync,
  output logic         frameDone,
  output link_strobe_t strobes
);

  localparam int FRAME_BITS = SLOT_W * NUM_SLOTS;
  localparam int POS_W      = $clog2(FRAME_BITS);
  localparam int BIT_W      = $clog2(SLOT_W);
  localparam int SEL_W      = POS_W - BIT_W;

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);
  localparam logic [POS_W-1:0] SYNC_PRE = POS_W'(FRAME_BITS - 2);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SLOT_W - 1);
  localparam logic [SEL_W-1:0] LAST_RX  = SEL_W'(RX_SLOTS - 1);

  // Two synchronizer stages plus one history stage for edge detection.
  logic [2:0]       clkSync;
  logic             fallEdge;
  logic [POS_W-1:0] pos;
  logic [SEL_W-1:0] slotNow;
  logic [BIT_W-1:0] bitNow;

  always_ff @(posedge clk) begin
    if (!rst_n) clkSync <= '0;
    else        clkSync <= {clkSync[1:0], bitClk};
  end

  assign fallEdge = clkSync[2] & ~clkSync[1];
  assign slotNow  = pos[POS_W-1:BIT_W];
  assign bitNow   = pos[BIT_W-1:0];

  // pos is the bit position currently on the wire; reset puts it just ahead
  // of the sync bit, so the first edge opens a frame.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos       <= SYNC_PRE;
      frameSync <= 1'b0;
      frameDone <= 1'b0;
    end else begin
      frameDone <= fallEdge && (pos == LAST_POS);
      if (fallEdge) begin
        pos       <= pos + POS_W'(1);
        frameSync <= (pos == SYNC_PRE);
      end
    end
  end

  always_comb begin
    strobes.tick    = fallEdge;
    strobes.loadTx  = fallEdge && (pos == SYNC_PRE);
    strobes.wordEnd = fallEdge && (bitNow == LAST_BIT) && (slotNow <= LAST_RX);
    strobes.publish = fallEdge && (bitNow == LAST_BIT) && (slotNow == LAST_RX);
    strobes.slotIdx = SLOT_IDX_W'(slotNow);
  end

endmodule

// File: rtl/tdm_link_data.sv
module tdm_link_data
  import tdm_link_pkg::*;
#(
  parameter int SLOT_W    = 16,
  parameter int NUM_SLOTS = 16,
  parameter int RX_SLOTS  = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  link_strobe_t               strobes,
  input  logic [NUM_SLOTS*SLOT_W-1:0] txSlots,
  input  logic                       sdIn,
  output logic                       sdOut,
  output logic [RX_SLOTS*SLOT_W-1:0] rxSlots,
  output logic                       rxValid
);

  localparam int FRAME_BITS = SLOT_W * NUM_SLOTS;

  logic [FRAME_BITS-1:0] txFlat;
  logic [FRAME_BITS-1:0] txShift;
  logic [SLOT_W-2:0]     rxShift;
  logic [SLOT_W-1:0]     newWord;
  logic [SLOT_W-1:0]     collect [RX_SLOTS-1];
  logic [SLOT_W-1:0]     rxBank  [RX_SLOTS];

  // Put slot 0 at the top of the frame image so the shift order is slot-major, MSB first.
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_txFlat
    assign txFlat[FRAME_BITS-1-s*SLOT_W -: SLOT_W] = txSlots[s*SLOT_W +: SLOT_W];
  end

  // Transmit: send the top bit of the frame image at each edge. The edge that
  // starts the sync bit sends the previous frame's last bit and then reloads.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sdOut   <= 1'b0;
      txShift <= '0;
    end else if (strobes.tick) begin
      sdOut <= txShift[FRAME_BITS-1];
      if (strobes.loadTx) txShift <= txFlat;
      else                txShift <= {txShift[FRAME_BITS-2:0], 1'b0};
    end
  end

  // Receive: the bit that ends at this edge is appended to the running word.
  assign newWord = {rxShift, sdIn};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxShift <= '0;
      rxValid <= 1'b0;
      for (int s = 0; s < RX_SLOTS - 1; s++) collect[s] <= '0;
      for (int s = 0; s < RX_SLOTS; s++)     rxBank[s]  <= '0;
    end else begin
      rxValid <= strobes.publish;
      if (strobes.tick) rxShift <= newWord[SLOT_W-2:0];
      for (int s = 0; s < RX_SLOTS - 1; s++) begin
        if (strobes.wordEnd && strobes.slotIdx == SLOT_IDX_W'(s)) collect[s] <= newWord;
      end
      if (strobes.publish) begin
        for (int s = 0; s < RX_SLOTS - 1; s++) rxBank[s] <= collect[s];
        rxBank[RX_SLOTS-1] <= newWord;
      end
    end
  end

  for (genvar s = 0; s < RX_SLOTS; s++) begin : g_rxOut
    assign rxSlots[s*SLOT_W +: SLOT_W] = rxBank[s];
  end

endmodule

// File: rtl/tdm_link_engine.sv
module tdm_link_engine
  import tdm_link_pkg::*;
#(
  parameter int SLOT_W    = 16,
  parameter int NUM_SLOTS = 16,
  parameter int RX_SLOTS  = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bitClk,
  input  logic                        sdIn,
  input  logic [NUM_SLOTS*SLOT_W-1:0] txSlots,
  output logic                        sdOut,
  output logic                        frameSync,
  output logic                        frameDone,
  output logic [RX_SLOTS*SLOT_W-1:0]  rxSlots,
  output logic                        rxValid
);

  link_strobe_t strobes;
  logic         bitTick;

  assign bitTick = strobes.tick;

  tdm_link_ctrl #(
    .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS), .RX_SLOTS(RX_SLOTS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .bitClk(bitClk),
    .frameSync(frameSync), .frameDone(frameDone), .strobes(strobes)
  );

  tdm_link_data #(
    .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS), .RX_SLOTS(RX_SLOTS)
  ) u_data (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .txSlots(txSlots),
    .sdIn(sdIn), .sdOut(sdOut), .rxSlots(rxSlots), .rxValid(rxValid)
  );

endmodule

// File: rtl/tdm_link_engine_chk.sv
module tdm_link_engine_chk #(
  parameter int RX_BITS = 80
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bitTick,
  input logic               sdOut,
  input logic               frameSync,
  input logic               frameDone,
  input logic               rxValid,
  input logic [RX_BITS-1:0] rxSlots
);

  // R3: serial output moves only after a bit-clock falling edge
  p_sdout_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdOut) |-> $past(bitTick));

  // R2: frame sync moves only after a bit-clock falling edge
  p_sync_on_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frameSync) |-> $past(bitTick));

  // R6: frame-done is a single-cycle strobe
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frameDone |=> !frameDone);

  // R6: frame-done rises exactly when the sync bit ends
  p_done_at_sync_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frameSync) |-> frameDone);

  p_sync_end_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frameDone |-> $fell(frameSync));

  // R5: receive-valid is a single-cycle strobe, never at a frame boundary
  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rxValid |=> !rxValid);

  p_valid_not_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rxValid |-> !frameDone);

  // R7: the receive bank changes only together with receive-valid
  p_rx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rxSlots) |-> rxValid);

endmodule

bind tdm_link_engine tdm_link_engine_chk #(.RX_BITS(RX_SLOTS*SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bitTick(bitTick), .sdOut(sdOut),
  .frameSync(frameSync), .frameDone(frameDone), .rxValid(rxValid), .rxSlots(rxSlots)
);

// File: tb/tdm_link_engine_test.sv
module tdm_link_engine_test;

  localparam int SW  = 16;
  localparam int NS  = 16;
  localparam int RX  = 5;
  localparam int FB  = SW * NS;
  localparam int NFR = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bitClk = 1'b1;
  logic          sdIn = 1'b0;
  logic [NS*SW-1:0] txSlots;
  logic          sdOut, frameSync, frameDone, rxValid;
  logic [RX*SW-1:0] rxSlots;

  int tests = 0;
  int failed = 0;

  int doneCnt = 0;
  int validCnt = 0;
  logic [RX*SW-1:0] capRx = '0;

  logic [SW-1:0] curExp [NS];
  logic [SW-1:0] txCur  [NS];

  always #5 clk = ~clk;

  tdm_link_engine #(.SLOT_W(SW), .NUM_SLOTS(NS), .RX_SLOTS(RX)) uut (
    .clk(clk), .rst_n(rst_n), .bitClk(bitClk), .sdIn(sdIn), .txSlots(txSlots),
    .sdOut(sdOut), .frameSync(frameSync), .frameDone(frameDone),
    .rxSlots(rxSlots), .rxValid(rxValid)
  );

  always @(negedge clk) begin
    if (frameDone) doneCnt++;
    if (rxValid) begin
      validCnt++;
      capRx = rxSlots;
    end
  end

  function automatic logic [SW-1:0] txPat(int f, int s);
    logic [SW-1:0] w;
    case (f % 6)
      0: w = 16'h0000;
      1: w = 16'hFFFF;
      2: w = 16'(32'd1 << s);
      3: w = (s % 2 == 1) ? 16'hAAAA : 16'h5555;
      4: w = 16'(s * 32'h1111) ^ 16'h0F0F;
      default: w = 16'(f * 32'h2357 + s * 32'h1B3D);
    endcase
    return w;
  endfunction

  function automatic logic [SW-1:0] rxPat(int f, int s);
    return txPat(f + 3, s) ^ 16'h3C3C ^ 16'(s);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic driveTx();
    for (int s = 0; s < NS; s++) txSlots[s*SW +: SW] = txCur[s];
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  endtask

  initial begin
    #1_000_000;
    tests++;
    failed++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    finishRun();
  end

  initial begin
    int p;
    int frm;
    int syncErr, txErr, doneErr, validErr;
    logic expBit, fsExp;

    for (int s = 0; s < NS; s++) begin
      txCur[s]  = txPat(0, s);
      curExp[s] = '0;
    end
    driveTx();

    repeat (6) @(negedge clk);
    // R1: reset state, checked during reset and after release before any edge
    check(sdOut === 1'b0 && frameSync === 1'b0, "R1 serial outputs in reset",
          {sdOut, frameSync}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(sdOut === 1'b0, "R1 sdOut after reset", sdOut, 0);
    check(frameSync === 1'b0, "R1 frameSync after reset", frameSync, 0);
    check(frameDone === 1'b0 && rxValid === 1'b0, "R1 strobes after reset",
          {frameDone, rxValid}, 0);
    check(rxSlots === '0, "R1 rxSlots after reset", rxSlots, 0);
    doneCnt = 0;
    validCnt = 0;

    frm = -1;
    syncErr = 0; txErr = 0; doneErr = 0; validErr = 0;
    for (int n = 0; n < 1 + NFR * FB; n++) begin
      p = (n == 0) ? FB - 1 : (n - 1) % FB;
      if (p == 0) frm++;

      // one bit-clock period: falling edge, then drive sdIn on the rising edge
      bitClk = 1'b0;
      #40;
      bitClk = 1'b1;
      sdIn = (frm < 0) ? 1'b0 : rxPat(frm, p / SW)[SW-1 - p % SW];
      #35;

      // R2: sync only in the last bit of each frame
      fsExp = (p == FB - 1);
      if (frameSync !== fsExp) syncErr++;
      // R3: slot-major, MSB-first serial order
      if (p == FB - 1) expBit = curExp[NS-1][0];
      else             expBit = curExp[p / SW][SW-1 - p % SW];
      if (sdOut !== expBit) txErr++;

      // R6: frame boundary strobe after the last bit of slot 15
      if (p == 0) check(doneCnt == 1, "R6 frameDone one cycle at frame boundary", doneCnt, 1);
      else if (doneCnt != 0) doneErr++;

      // R5: bank update after the last bit of slot 4
      if (p == RX * SW && frm >= 0) begin
        check(validCnt == 1, "R5 rxValid one cycle after slot 4", validCnt, 1);
        for (int s = 0; s < RX; s++)
          check(capRx[s*SW +: SW] === rxPat(frm, s), "R5 received slot word",
                capRx[s*SW +: SW], rxPat(frm, s));
      end else if (validCnt != 0) validErr++;
      doneCnt = 0;
      validCnt = 0;

      // R4: rewrite the array mid-frame; it belongs to the next frame
      if (p == 100) begin
        for (int s = 0; s < NS; s++) txCur[s] = txPat(frm + 1, s);
        driveTx();
      end

      if (p == FB - 1) begin
        if (frm >= 0) begin
          check(syncErr == 0, "R2 frameSync position errors in frame", syncErr, 0);
          check(txErr == 0, "R3 R4 sdOut bit errors in frame", txErr, 0);
          check(doneErr == 0, "R6 stray frameDone in frame", doneErr, 0);
          check(validErr == 0, "R5 stray rxValid in frame", validErr, 0);
          check(rxSlots === capRx, "R7 rxSlots held despite slots 5-15 data", rxSlots, capRx);
        end
        syncErr = 0; txErr = 0; doneErr = 0; validErr = 0;
        for (int s = 0; s < NS; s++) curExp[s] = txCur[s];
      end
      #5;
    end
    finishRun();
  end

endmodule